// File: doc/BRIEF.md
# Far-End Alarm Codeword Receiver

This block watches a serial far-end alarm and control channel, one bit per enable strobe, and picks out 16-bit codewords. Each codeword starts with eight ones, followed by a zero, six code bits and a trailing zero. A code is accepted only after it has repeated often enough. Each accepted code goes into a small receive queue.

The block also spots the line going idle after an accepted code. It reports everything through one 16-bit status word. Reading that word pops the queue head and clears the latched event flags. An interrupt output combines the latched events with two enable inputs.

Top module: `feac_rx`

## Requirements
- R1: A codeword is framed when the most recent 16 strobed bits are, in arrival order: eight ones, a zero, six code bits and a zero. The first code bit to arrive is code bit 0 and the last is code bit 5.
- R2: A framed code is accepted only when it matches at least 8 of the 10 most recent framed codewords, counting itself. Fewer matches push nothing.
- R3: Further repeats of the code that is currently accepted push nothing and do not set status bit 0.
- R4: Accepted codes enter a 4-entry first-in first-out queue. Status bits 13:8 show the oldest entry, and a status read removes that entry when the queue is not empty.
- R5: Status bit 14 is 1 exactly when the queue holds no entry. It is not latched.
- R6: An accepted code that finds the queue full is dropped and sets status bit 15. A read clears bit 15, and it sets again only on a later drop.
- R7: Status bit 0 latches on each accepted code and clears on a read.
- R8: Status bit 1 latches when 16 consecutive ones arrive while a code is accepted. The same event also forgets the accepted code and the repetition history, so the same code can be accepted again. A read clears bit 1.
- R9: `irq` is high exactly when `mask_feac` is 1 and either status bit 0 is set, or status bit 1 and `idle_ie` are both set.
- R10: An event that latches in the same cycle as a read stays set after that read.
- R11: Synchronous active-high reset empties the queue, clears all flags and the framing history, and leaves the status word at 16'h4000.
- R12: Status bits 7:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a cycle carrying a channel bit |
| bit_in | input | 1 | Channel bit |
| rd_en | input | 1 | Status read strobe: pops the queue head and clears the latched flags |
| mask_feac | input | 1 | Master interrupt enable |
| idle_ie | input | 1 | Lets the idle flag drive the interrupt |
| status | output | 16 | Status word, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a code that reaches its eighth vote from a mixed history. Short bursts of one code interleave with other codes, so acceptance can land before the eighth consecutive repeat. The bench reaches this with random burst lengths over random codes and keeps its own vote history to predict every acceptance.

A second hard case is a read landing on the exact cycle a codeword completes. The bench drives a read on the closing bit of a validating codeword, both as a directed case and at random.

// File: rtl/feac_rx.sv
module feac_rx #(
  parameter int DEPTH  = 4,
  parameter int WIN    = 10,
  parameter int THRESH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bit_en,
  input  logic        bit_in,
  input  logic        rd_en,
  input  logic        mask_feac,
  input  logic        idle_ie,
  output logic [15:0] status,
  output logic        irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HW = $clog2(WIN + 1);

  logic [15:0] sr;
  logic [5:0]  hist [WIN-1];
  logic [WIN-2:0] hist_v;
  logic [HW-1:0]  votes;
  logic        acc_vld;
  logic [5:0]  acc_code;
  logic [4:0]  ones;
  logic [5:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic        cd_q, idle_q, ovf_q;

  wire [15:0] sr_nx  = {bit_in, sr[15:1]};
  wire        framed = bit_en && sr_nx[7:0] == 8'hFF && !sr_nx[8] && !sr_nx[15];
  wire [5:0]  code   = sr_nx[14:9];

  always_comb begin
    votes = HW'(1);
    for (int i = 0; i < WIN - 1; i++)
      if (hist_v[i] && hist[i] == code) votes = votes + HW'(1);
  end

  wire accept   = framed && votes >= HW'(THRESH) && (!acc_vld || code != acc_code);
  wire idle_hit = bit_en && bit_in && acc_vld && ones == 5'd15;
  wire empty    = cnt == '0;
  wire pop      = rd_en && !empty;
  wire push     = accept && (cnt != CW'(DEPTH) || pop);
  wire ovf_hit  = accept && !push;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      hist_v   <= '0;
      acc_vld  <= 1'b0;
      acc_code <= '0;
      ones     <= '0;
    end else begin
      if (bit_en) begin
        sr   <= sr_nx;
        ones <= !bit_in ? 5'd0 : (ones == 5'd16 ? ones : ones + 5'd1);
      end
      if (framed) begin
        hist[0] <= code;
        for (int i = 1; i < WIN - 1; i++) hist[i] <= hist[i-1];
        hist_v  <= {hist_v[WIN-3:0], 1'b1};
      end
      if (accept) begin
        acc_vld  <= 1'b1;
        acc_code <= code;
      end
      if (idle_hit) begin
        acc_vld <= 1'b0;
        hist_v  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= code;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_q   <= 1'b0;
      idle_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cd_q   <= accept   | (cd_q   & ~rd_en);
      idle_q <= idle_hit | (idle_q & ~rd_en);
      ovf_q  <= ovf_hit  | (ovf_q  & ~rd_en);
    end
  end

  assign status = {ovf_q, empty, empty ? 6'd0 : mem[rp], 6'd0, idle_q, cd_q};
  assign irq    = mask_feac & (cd_q | (idle_ie & idle_q));

  a_r11_reset_state: assert property (@(posedge clk) rst |=> status == 16'h4000);
  a_r4_fifo_bound:   assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  a_r7_event_latch:  assert property (@(posedge clk) disable iff (rst) accept |=> status[0]);
  a_r10_keep_event:  assert property (@(posedge clk) disable iff (rst) (rd_en && accept) |=> status[0]);
  a_r7_clear_read:   assert property (@(posedge clk) disable iff (rst) (rd_en && !accept) |=> !status[0]);
  a_r6_ovf_latch:    assert property (@(posedge clk) disable iff (rst) ovf_hit |=> status[15]);
  a_r6_no_drop_room: assert property (@(posedge clk) disable iff (rst) (accept && empty) |=> !status[14]);
  a_r8_idle_latch:   assert property (@(posedge clk) disable iff (rst) idle_hit |=> status[1]);
  a_r9_irq_masked:   assert property (@(posedge clk) disable iff (rst) !mask_feac |-> !irq);
  a_r12_zero_bits:   assert property (@(posedge clk) disable iff (rst) status[7:2] == 6'd0);
endmodule

// File: tb/feac_rx_tb.sv
module feac_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, bit_in = 1'b0, rd_en = 1'b0;
  logic mask_feac = 1'b0, idle_ie = 1'b0;
  logic [15:0] status;
  logic irq;

  int checks = 0, fails = 0;
  bit reported = 0;

  int  hq[$];
  int  mq[$];
  bit  m_acc = 0, m_cd = 0, m_idl = 0, m_ovf = 0;
  int  m_code = 0;

  feac_rx u_dut (.clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .rd_en(rd_en),
                 .mask_feac(mask_feac), .idle_ie(idle_ie), .status(status), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic int votes(int c);
    int n = 1;
    for (int i = 0; i < hq.size() && i < 9; i++) if (hq[i] == c) n++;
    return n;
  endfunction

  function automatic bit exp_irq(bit m, bit ie);
    return m && (m_cd || (ie && m_idl));
  endfunction

  task automatic model_word(int c);
    int v = votes(c);
    hq.push_front(c);
    if (hq.size() > 9) void'(hq.pop_back());
    if (v >= 8 && (!m_acc || c != m_code)) begin
      m_acc = 1; m_code = c; m_cd = 1;
      if (mq.size() < 4) mq.push_back(c); else m_ovf = 1;
    end
  endtask

  task automatic model_idle();
    if (m_acc) begin
      m_idl = 1; m_acc = 0; hq.delete();
    end
  endtask

  task automatic model_read();
    m_cd = 0; m_idl = 0; m_ovf = 0;
    if (mq.size() > 0) void'(mq.pop_front());
  endtask

  task automatic check_status();
    chk("R7 cd flag", status[0], m_cd);
    chk("R8 idle flag", status[1], m_idl);
    chk("R12 zero bits", status[7:2], 0);
    chk("R5 empty", status[14], mq.size() == 0);
    chk("R6 overflow", status[15], m_ovf);
    if (mq.size() > 0) chk("R4 head data", status[13:8], mq[0]);
    chk("R9 irq", irq, exp_irq(mask_feac, idle_ie));
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    rd_en = 0; bit_en = 1; bit_in = b;
  endtask

  task automatic stop_bits();
    @(negedge clk);
    rd_en = 0; bit_en = 0; bit_in = 0;
  endtask

  task automatic send_word(int c, bit rd_last);
    logic [15:0] w = {1'b0, 6'(c), 1'b0, 8'hFF};
    for (int i = 0; i < 15; i++) send_bit(w[i]);
    @(negedge clk);
    bit_en = 1; bit_in = w[15]; rd_en = 0;
    if (rd_last) begin
      rd_en = 1;
      mask_feac = 1'($urandom); idle_ie = 1'($urandom);
      #1;
      check_status();
      model_read();
    end
    model_word(c);
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
    if (n >= 16) model_idle();
  endtask

  task automatic do_read();
    @(negedge clk);
    bit_en = 0; rd_en = 1;
    mask_feac = 1'($urandom); idle_ie = 1'($urandom);
    #1;
    check_status();
    model_read();
    @(posedge clk);
    #1 rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset status", status, 16'h4000);
    chk("R11 reset irq", irq, 0);

    // R1, R2: seven repeats are not enough, the eighth accepts code 1
    for (int k = 0; k < 7; k++) send_word(1, 0);
    stop_bits();
    chk("R2 seven repeats leave queue empty", status[14], 1);
    send_word(1, 0);
    stop_bits();
    chk("R2 eighth repeat accepts", status[14], 0);
    chk("R1 bit order code bit0 first", status[13:8], 6'd1);
    chk("R7 cd latched", status[0], 1);
    do_read();

    // R3: repeats of the accepted code push nothing
    for (int k = 0; k < 4; k++) send_word(1, 0);
    stop_bits();
    chk("R3 no second push", status[14], 1);
    chk("R3 no new event", status[0], 0);

    // R8, R9: idle after the accepted code, then re-acceptance
    send_ones(16);
    stop_bits();
    chk("R8 idle latched", status[1], 1);
    mask_feac = 1; idle_ie = 0; #1;
    chk("R9 idle masked by idle_ie", irq, 0);
    idle_ie = 1; #1;
    chk("R9 idle drives irq", irq, 1);
    do_read();
    for (int k = 0; k < 8; k++) send_word(1, 0);
    stop_bits();
    chk("R8 same code accepted after idle", status[14], 0);
    do_read();

    // R6: five distinct accepted codes into a 4-entry queue
    for (int c = 0; c < 5; c++) for (int k = 0; k < 8; k++) send_word(40 + c, 0);
    stop_bits();
    chk("R6 overflow latched", status[15], 1);
    for (int k = 0; k < 5; k++) do_read();

    // R10: read in the cycle that validates a new code
    for (int k = 0; k < 7; k++) send_word(21, 0);
    send_word(21, 1);
    stop_bits();
    chk("R10 event kept across read", status[0], 1);
    chk("R10 code queued", status[14], 0);
    do_read();

    // random bursts with a vote-history model
    for (int b = 0; b < 60; b++) begin
      int c = int'($urandom % 64);
      int n = int'($urandom % 12) + 1;
      for (int k = 0; k < n; k++) begin
        send_word(c, ($urandom % 8) == 0);
        if ($urandom % 4 == 0) begin
          stop_bits();
          do_read();
        end
      end
      if ($urandom % 5 == 0) send_ones(16 + int'($urandom % 5));
    end
    stop_bits();
    for (int k = 0; k < 6; k++) do_read();
    report();
  end
endmodule